// File: doc/BRIEF.md
# Output Driver Fault Supervisor

This block is the sequential protection layer in front of six power switch outputs. It takes the control bits already committed by the serial port, along with the comparator flags from the analog side. Those flags are: supply out of range, overcurrent on each output, temperature warning and temperature shutdown. It also takes the hardware run pin. From these it produces the gated enable for each switch and a 16-bit status word that the serial port shifts out.

Fault delays are counted in ticks of a slow oscillator. A single delay-select control bit chooses between a long and a short delay at run time. The supply fault and the short-circuit fault each use their own pair of delays:

- Supply fault: 14 ms long, 3.5 ms short.
- Short circuit: 100 ms long, 12.5 ms short.

Tick counts are derived from the `TICK_KHZ` parameter. A supply fault, a short circuit and a thermal shutdown each leave a sticky record. Only a clear pulse, produced when the status-reset control bit is committed high, removes that record.

Top module: `fault_supervisor`

## Requirements
- R1: After reset, with no faults and no outputs requested, every enable is low and the status word is zero except bit 14, which reflects the run inputs.
- R2: With both run inputs high and no fault, `drv_en[i]` equals `ctl_on[i]`, and status bits 1 to 6 show `drv_en[0]` to `drv_en[5]`.
- R3: When `inh_pin` is low or `ctl_run` is low, all enables are low and status bit 14 reads 1; otherwise bit 14 reads 0.
- R4: Once `supply_bad` has held for N supply delay ticks, all enables drop and status bit 15 sets. N is 14 ms of ticks with `ctl_slow`=1 and 3.5 ms of ticks with `ctl_slow`=0. After N-1 ticks the outputs are still on.
- R5: When `supply_bad` goes low, the enables return at once. Bit 15 stays set until a `ctl_clr` pulse.
- R6: An overcurrent held for the short-circuit delay disables only that output and sets status bit 13. The delay is 100 ms of ticks when `ctl_slow`=1 and 12.5 ms when `ctl_slow`=0. The output stays off after the overcurrent ends.
- R7: An overcurrent while `tw_warn` is high disables that output on the next clock and sets bit 13.
- R8: A `ctl_clr` pulse clears bit 13 and re-enables the outputs that were shut off by short circuit.
- R9: A delay counter restarts from zero whenever its fault condition goes away before the delay expires.
- R10: Status bit 0 follows `tw_warn`.
- R11: `tw_shut` drops all enables and forces all 16 status bits to 1. This state ends only through a `ctl_clr` pulse given after `tw_shut` has fallen; a clear pulse while the temperature is still high has no effect.
- R12: When `ol_enable`=1, `ctl_run`=1 and `ctl_on[i]`=0, status bit i+1 shows `ol_flag[i]` rather than the drive state. Status bits 7 to 12 are always 0 outside thermal shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse from the slow time-base oscillator |
| ctl_on | input | 6 | Committed on request per output |
| ctl_clr | input | 1 | One-cycle pulse when the status-reset bit is committed high |
| ctl_slow | input | 1 | Delay select: 1 = long delays, 0 = short delays |
| ol_enable | input | 1 | Open-load sensing enable |
| ctl_run | input | 1 | Software run bit (0 = standby) |
| inh_pin | input | 1 | Hardware run pin (0 = standby) |
| supply_bad | input | 1 | Supply over/undervoltage comparator |
| ovc | input | 6 | Overcurrent comparator per output |
| tw_warn | input | 1 | Temperature warning comparator |
| tw_shut | input | 1 | Temperature shutdown comparator |
| ol_flag | input | 6 | Open-load comparator per output |
| drv_en | output | 6 | Gated enable per output |
| status | output | 16 | Status word for the serial port |

## Verification
The hardest case to reach is the exact edge of each delay. The bench must show that an output is still on one tick before expiry and off on the expiring tick, and it must do this for both delay-select settings. The bench owns the tick input and produces each tick as an isolated pulse, so it can stop after exactly N-1 ticks, check, and then give the final tick. The same control over ticks is used to show the counter restarting: the fault is interrupted partway through and then re-applied, and the total number of ticks exceeds the delay while no single run reaches it.

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int N_OUT    = 6,
  parameter int TICK_KHZ = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [N_OUT-1:0] ctl_on,
  input  logic             ctl_clr,
  input  logic             ctl_slow,
  input  logic             ol_enable,
  input  logic             ctl_run,
  input  logic             inh_pin,
  input  logic             supply_bad,
  input  logic [N_OUT-1:0] ovc,
  input  logic             tw_warn,
  input  logic             tw_shut,
  input  logic [N_OUT-1:0] ol_flag,
  output logic [N_OUT-1:0] drv_en,
  output logic [15:0]      status
);
  localparam int SUP_LONG  = 14 * TICK_KHZ;
  localparam int SUP_SHORT = (7 * TICK_KHZ + 1) / 2;
  localparam int SC_LONG   = 100 * TICK_KHZ;
  localparam int SC_SHORT  = (25 * TICK_KHZ + 1) / 2;
  localparam int CW        = $clog2(SC_LONG + 1);

  logic [CW-1:0] sup_cnt;
  logic [CW-1:0] sup_lim, sc_lim;
  logic          sup_hit, psf, scd, shut_lat;
  logic [N_OUT-1:0] sc_off, trip;
  logic          run, gate;

  assign sup_lim = ctl_slow ? CW'(SUP_LONG) : CW'(SUP_SHORT);
  assign sc_lim  = ctl_slow ? CW'(SC_LONG)  : CW'(SC_SHORT);
  assign sup_hit = supply_bad && (sup_cnt >= sup_lim);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 sup_cnt <= '0;
    else if (!supply_bad)       sup_cnt <= '0;
    else if (tick && !sup_hit)  sup_cnt <= sup_cnt + CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        psf <= 1'b0;
    else if (ctl_clr)  psf <= 1'b0;
    else if (sup_hit)  psf <= 1'b1;

  for (genvar g = 0; g < N_OUT; g++) begin : g_sc
    logic [CW-1:0] cnt;
    logic          expired;
    assign expired = ovc[g] && (cnt >= sc_lim);
    assign trip[g] = ovc[g] && (tw_warn || expired);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                cnt <= '0;
      else if (!ovc[g])          cnt <= '0;
      else if (tick && !expired) cnt <= cnt + CW'(1);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        sc_off[g] <= 1'b0;
      else if (ctl_clr)  sc_off[g] <= 1'b0;
      else if (trip[g])  sc_off[g] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        scd <= 1'b0;
    else if (ctl_clr)  scd <= 1'b0;
    else if (|trip)    scd <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        shut_lat <= 1'b0;
    else if (tw_shut)  shut_lat <= 1'b1;
    else if (ctl_clr)  shut_lat <= 1'b0;

  assign run    = inh_pin & ctl_run;
  assign gate   = run & ~sup_hit & ~shut_lat;
  assign drv_en = ctl_on & ~sc_off & {N_OUT{gate}};

  always_comb begin
    status = '0;
    if (shut_lat) status = '1;
    else begin
      status[0]  = tw_warn;
      for (int i = 0; i < N_OUT; i++)
        status[i+1] = (ol_enable && ctl_run && !ctl_on[i]) ? ol_flag[i] : drv_en[i];
      status[13] = scd;
      status[14] = ~run;
      status[15] = psf;
    end
  end
endmodule

module fault_supervisor_chk #(
  parameter int N_OUT = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_clr,
  input logic             ctl_run,
  input logic             inh_pin,
  input logic [N_OUT-1:0] ovc,
  input logic             tw_warn,
  input logic             tw_shut,
  input logic [N_OUT-1:0] drv_en,
  input logic [15:0]      status
);
  assert_inhibit_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(inh_pin && ctl_run) |-> (drv_en == '0 && status[14]));

  assert_psf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[15] && !ctl_clr) |=> status[15]);

  assert_warn_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (((ovc & {N_OUT{tw_warn}}) != '0) && !ctl_clr) |=> ((drv_en & $past(ovc)) == '0));

  assert_scd_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (((ovc & {N_OUT{tw_warn}}) != '0) && !ctl_clr) |=> status[13]);

  assert_shut_ones_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tw_shut |=> (status == 16'hFFFF && drv_en == '0));

  assert_tp_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] != tw_warn) |-> (status == 16'hFFFF));

  assert_unused_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 16'hFFFF) |-> (status[12:7] == '0));
endmodule

bind fault_supervisor fault_supervisor_chk #(.N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_clr(ctl_clr), .ctl_run(ctl_run),
  .inh_pin(inh_pin), .ovc(ovc), .tw_warn(tw_warn), .tw_shut(tw_shut),
  .drv_en(drv_en), .status(status)
);

// File: tb/fault_supervisor_test.sv
module fault_supervisor_test;
  localparam int KHZ    = 2;
  localparam int SUP_L  = 14 * KHZ;
  localparam int SUP_S  = (7 * KHZ + 1) / 2;
  localparam int SC_S   = (25 * KHZ + 1) / 2;

  logic clk = 0, rst_n = 0, tick = 0;
  logic [5:0] ctl_on = 0, ovc = 0, ol_flag = 0;
  logic ctl_clr = 0, ctl_slow = 0, ol_enable = 0, ctl_run = 1, inh_pin = 1;
  logic supply_bad = 0, tw_warn = 0, tw_shut = 0;
  logic [5:0] drv_en;
  logic [15:0] status;

  fault_supervisor #(.N_OUT(6), .TICK_KHZ(KHZ)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_on(ctl_on), .ctl_clr(ctl_clr),
    .ctl_slow(ctl_slow), .ol_enable(ol_enable), .ctl_run(ctl_run), .inh_pin(inh_pin),
    .supply_bad(supply_bad), .ovc(ovc), .tw_warn(tw_warn), .tw_shut(tw_shut),
    .ol_flag(ol_flag), .drv_en(drv_en), .status(status));

  always #4 clk = ~clk;

  typedef struct {
    string       req;
    logic [5:0]  en;
    logic [15:0] st;
  } item_t;
  item_t q[$];
  int compared = 0, mismatched = 0;
  bit done = 0;

  function automatic logic [15:0] stw(bit psf, bit inh, bit scd, logic [5:0] ch, bit tp);
    return {psf, inh, scd, 6'b0, ch, tp};
  endfunction

  task automatic expect_out(string req, logic [5:0] en, logic [15:0] st);
    item_t it;
    it.req = req; it.en = en; it.st = st;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  initial forever begin
    item_t it;
    wait (q.size() != 0);
    it = q[0];
    compared++;
    if (drv_en !== it.en || status !== it.st) begin
      mismatched++;
      $display("FAIL %s: drv_en=%b status=%h expected drv_en=%b status=%h",
               it.req, drv_en, status, it.en, it.st);
    end
    void'(q.pop_front());
  end

  task automatic settle(); @(negedge clk); endtask
  task automatic run_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
    end
  endtask
  task automatic pulse_clr();
    @(negedge clk) ctl_clr = 1;
    @(negedge clk) ctl_clr = 0;
    settle();
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    expect_out("R1 reset", 6'b0, stw(0, 0, 0, 6'b0, 0));

    ctl_on = 6'b101101; settle();
    expect_out("R2 pattern a", 6'b101101, stw(0, 0, 0, 6'b101101, 0));
    ctl_on = 6'b010010; settle();
    expect_out("R2 pattern b", 6'b010010, stw(0, 0, 0, 6'b010010, 0));

    inh_pin = 0; settle();
    expect_out("R3 pin low", 6'b0, stw(0, 1, 0, 6'b0, 0));
    inh_pin = 1; ctl_run = 0; settle();
    expect_out("R3 run bit low", 6'b0, stw(0, 1, 0, 6'b0, 0));
    ctl_run = 1;

    ol_enable = 1; ctl_on = 6'b000011; ol_flag = 6'b110100; settle();
    expect_out("R12 open-load view", 6'b000011, stw(0, 0, 0, 6'b110111, 0));
    ctl_run = 0; settle();
    expect_out("R12 software standby hides open-load", 6'b0, stw(0, 1, 0, 6'b0, 0));
    ctl_run = 1; ol_enable = 0; ol_flag = 0;

    ctl_on = 6'b111111; ctl_slow = 0; supply_bad = 1;
    run_ticks(SUP_S - 1); settle();
    expect_out("R4 short delay not yet", 6'h3F, stw(0, 0, 0, 6'h3F, 0));
    run_ticks(1); settle();
    expect_out("R4 short delay expired", 6'b0, stw(1, 0, 0, 6'b0, 0));
    supply_bad = 0; settle();
    expect_out("R5 outputs back, flag held", 6'h3F, stw(1, 0, 0, 6'h3F, 0));
    pulse_clr();
    expect_out("R5 flag cleared", 6'h3F, stw(0, 0, 0, 6'h3F, 0));

    ctl_slow = 1; supply_bad = 1;
    run_ticks(SUP_L - 1); settle();
    expect_out("R4 long delay not yet", 6'h3F, stw(0, 0, 0, 6'h3F, 0));
    run_ticks(1); settle();
    expect_out("R4 long delay expired", 6'b0, stw(1, 0, 0, 6'b0, 0));
    supply_bad = 0; pulse_clr();

    ctl_slow = 0; supply_bad = 1; run_ticks(SUP_S - 2);
    supply_bad = 0; settle();
    supply_bad = 1; run_ticks(SUP_S - 2); settle();
    expect_out("R9 counter restarted", 6'h3F, stw(0, 0, 0, 6'h3F, 0));
    supply_bad = 0; settle();

    ovc = 6'b000100; run_ticks(SC_S - 1); settle();
    expect_out("R6 short circuit not yet", 6'h3F, stw(0, 0, 0, 6'h3F, 0));
    run_ticks(1); settle();
    expect_out("R6 short circuit expired", 6'b111011, stw(0, 0, 1, 6'b111011, 0));
    ovc = 0; settle();
    expect_out("R6 stays off", 6'b111011, stw(0, 0, 1, 6'b111011, 0));
    pulse_clr();
    expect_out("R8 clear restores", 6'h3F, stw(0, 0, 0, 6'h3F, 0));

    tw_warn = 1; ovc = 6'b100000; settle();
    expect_out("R7 warning trip", 6'b011111, stw(0, 0, 1, 6'b011111, 1));
    ovc = 0; tw_warn = 0; pulse_clr();
    expect_out("R8 clear after warning trip", 6'h3F, stw(0, 0, 0, 6'h3F, 0));

    tw_warn = 1; settle();
    expect_out("R10 warning bit", 6'h3F, stw(0, 0, 0, 6'h3F, 1));
    tw_warn = 0; settle();
    expect_out("R10 warning bit gone", 6'h3F, stw(0, 0, 0, 6'h3F, 0));

    tw_shut = 1; settle();
    expect_out("R11 shutdown", 6'b0, 16'hFFFF);
    pulse_clr();
    expect_out("R11 clear while hot ignored", 6'b0, 16'hFFFF);
    tw_shut = 0; settle();
    expect_out("R11 cooled but latched", 6'b0, 16'hFFFF);
    pulse_clr();
    expect_out("R11 released", 6'h3F, stw(0, 0, 0, 6'h3F, 0));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule